// File: doc/BRIEF.md
# Shared-Source Interrupt Trigger Latch

This block sits in front of the request registers of two cascaded eight-input interrupt controllers, a primary (pins 0 to 7) and a secondary (pins 8 to 15). It turns per-pin assert, deassert and pulse events into one-cycle "set request" and "clear request" strobes. Each pin keeps a small count of outstanding assertions, so several sources can share one pin. The pin's request is released only when the last of those sources lets go, and only if the pin is level-triggered.

Each controller has an eight-bit trigger-mode register that marks each of its pins as edge-triggered or level-triggered. Some pins are hard-wired to edge mode: writes to those bit positions are dropped. When the secondary controller raises an interrupt, a cascade input pulses primary pin 2. Events aimed at a controller that has not finished initialization are dropped. Priority resolution and the request registers themselves live downstream.

Top module: `irq_trigger_latch`

## Requirements
- R1: An assert event (`ev_kind`=2'b01) adds one to the pin's 4-bit count and a deassert (`ev_kind`=2'b10) subtracts one. Pin p's count appears on `pin_count[4p+3:4p]`. `ev_kind`=2'b00 does nothing.
- R2: On an edge-triggered pin, a set strobe is produced only when the count moves from 0 to 1.
- R3: On a level-triggered pin, a set strobe is produced whenever an event leaves the count above zero. This includes a deassert from 3 to 2.
- R4: When a deassert takes the count from 1 to 0, a clear strobe is produced only on a level-triggered pin. An edge-triggered pin gets no clear strobe.
- R5: A pulse (`ev_kind`=2'b11) acts as an assert followed by a deassert within one cycle. When the deassert half clears, the set from the assert half is dropped, and set and clear are never high together for a pin.
- R6: Pins 0 to 7 use `ctl_ready[0]` and the primary trigger register. Pins 8 to 15 use `ctl_ready[1]` and the secondary trigger register. Each pin's bit position is its number mod 8, and a 1 means level-triggered.
- R7: Both trigger registers reset to 0 (all edge). A write with `cfg_sel`=0 stores `cfg_wdata & 8'hF8`, and with `cfg_sel`=1 stores `cfg_wdata & 8'hDE`, so pins 0, 1, 2, 8 and 13 stay edge-triggered. `cfg_rdata` returns the register picked by `cfg_sel`.
- R8: An event for a pin whose controller is not ready leaves that pin's count unchanged and produces no strobe.
- R9: `slave_raise` with `ctl_ready[0]` high pulses pin 2. In that cycle it takes the place of any event aimed at pin 2. With `ctl_ready[0]` low it has no effect.
- R10: A deassert at count 0 leaves the count at 0, produces no strobe, and sets `uflow_err`. `uflow_err` then stays high until reset.
- R11: An assert at count 15 leaves the count at 15. On an edge-triggered pin it produces no set strobe.
- R12: Counts update on the clock edge that samples the event. The strobes are high for exactly that following cycle. After reset all counts, strobes and `uflow_err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_ready | input | 2 | Initialization done, bit 0 primary, bit 1 secondary |
| ev_valid | input | 1 | Event present this cycle |
| ev_kind | input | 2 | 01 assert, 10 deassert, 11 pulse, 00 nothing |
| ev_pin | input | 4 | Target pin 0 to 15 |
| slave_raise | input | 1 | Secondary has raised an interrupt; pulse pin 2 |
| cfg_wr | input | 1 | Write the trigger register picked by cfg_sel |
| cfg_sel | input | 1 | 0 primary, 1 secondary trigger register |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Selected trigger register |
| req_set | output | 16 | One-cycle set strobe per pin |
| req_clr | output | 16 | One-cycle clear strobe per pin |
| pin_count | output | 64 | Four-bit assertion count per pin |
| uflow_err | output | 1 | Sticky count-underflow flag |

## Verification
The bench walks shared-pin sequences on edge and level pins. In these, a design that releases an edge request on the last deassert, or that fails to re-set a level request while the count stays positive, shows the wrong strobe. Pulses on level pins catch designs that report set and clear together or leave the request set. Deasserts at zero and asserts at fifteen expose counters that wrap instead of stopping. Further cases cover the fixed edge-only bits of the trigger registers, events dropped for a controller that is not ready, and a cascade pulse that collides with an event on pin 2; each exposes a wrongly latched request or a wrong count.

// File: rtl/irq_latch_pkg.sv
// Shared types for the interrupt trigger latch.
// Assumes: the event kind is two bits, with bit 0 meaning "count up" and
// bit 1 meaning "count down".
package irq_latch_pkg;
    typedef enum logic [1:0] {
        EV_NOP      = 2'b00,
        EV_ASSERT   = 2'b01,
        EV_DEASSERT = 2'b10,
        EV_PULSE    = 2'b11
    } ev_kind_e;
endpackage

// File: rtl/trig_mode_regs.sv
// Trigger-mode registers for the two controllers. A 1 in a bit makes that
// pin level-triggered. Each register has a fixed write mask, so hard-wired
// edge pins can never become level pins.
// Assumes: a single select line picks the register for both read and write.
module trig_mode_regs #(
    parameter int          REG_W  = 8,
    parameter logic [7:0]  MASK_P = 8'hF8,
    parameter logic [7:0]  MASK_S = 8'hDE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               sel,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rd_data,
    output logic [2*REG_W-1:0] level_o
);
    localparam logic [2*REG_W-1:0] MASKS = {REG_W'(MASK_S), REG_W'(MASK_P)};

    logic [REG_W-1:0] mode_q [2];

    for (genvar c = 0; c < 2; c++) begin : g_ctl
        // Hold one controller's trigger-mode bits, masked on write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mode_q[c] <= '0;
            else if (wr_en && (sel == c[0]))
                mode_q[c] <= wr_data & MASKS[c*REG_W +: REG_W];
        end
        assign level_o[c*REG_W +: REG_W] = mode_q[c];
    end

    assign rd_data = sel ? mode_q[1] : mode_q[0];

    AST_WR_MASKED_P: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel) |=> (level_o[REG_W-1:0] == ($past(wr_data) & REG_W'(MASK_P)))); // R7
    AST_WR_MASKED_S: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel) |=> (level_o[2*REG_W-1:REG_W] == ($past(wr_data) & REG_W'(MASK_S)))); // R7
endmodule

// File: rtl/pin_counter.sv
// Per-pin assertion counter with set/clear strobe generation.
// An up request and a down request in the same cycle form a pulse: the up
// half is applied first. The count stops at 0 and at its maximum instead of
// wrapping.
// Assumes: the level input is the pin's current trigger mode; the strobes are
// registered, and uflow_o is combinational for the parent's sticky flag.
module pin_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_inc,
    input  logic             do_dec,
    input  logic             level,
    output logic [CNT_W-1:0] cnt_q,
    output logic             set_q,
    output logic             clr_q,
    output logic             uflow_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] mid_cnt, fin_cnt;
    logic             set_up, set_dn, clr_dn;

    // Work out the assert half, then the deassert half, of this cycle's event.
    always_comb begin
        mid_cnt = cnt_q;
        set_up  = 1'b0;
        if (do_inc) begin
            mid_cnt = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
            set_up  = (cnt_q == '0) || level;
        end
        fin_cnt = mid_cnt;
        set_dn  = 1'b0;
        clr_dn  = 1'b0;
        uflow_o = 1'b0;
        if (do_dec) begin
            if (mid_cnt == '0) begin
                uflow_o = 1'b1;
            end else begin
                fin_cnt = mid_cnt - 1'b1;
                set_dn  = level && (fin_cnt != '0);
                clr_dn  = level && (fin_cnt == '0);
            end
        end
    end

    // Register the count and the one-cycle strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            set_q <= 1'b0;
            clr_q <= 1'b0;
        end else begin
            cnt_q <= fin_cnt;
            set_q <= (set_up || set_dn) && !clr_dn;
            clr_q <= clr_dn;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && do_inc && !do_dec) |=> (cnt_q == CNT_MAX)); // R11
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && do_dec && !do_inc) |=> (cnt_q == '0 && !set_q && !clr_q)); // R10
    AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_q && clr_q)); // R5
    AST_EDGE_KEEPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!level && do_dec) |=> !clr_q); // R4
    AST_LEVEL_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        (level && do_inc && !do_dec) |=> set_q); // R3
endmodule

// File: rtl/irq_trigger_latch.sv
// Top of the shared-source interrupt trigger latch for two cascaded
// controllers. It decodes events to per-pin up/down requests, gates them by
// controller readiness, injects the cascade pulse on the primary cascade pin,
// and collects per-pin strobes, counts and a sticky underflow flag.
// Assumes: at most one pin event per cycle; a cascade pulse takes the place
// of any event aimed at the cascade pin in the same cycle.
module irq_trigger_latch #(
    parameter int         PINS_PER_CTL = 8,
    parameter int         CNT_W        = 4,
    parameter int         CASCADE_PIN  = 2,
    parameter logic [7:0] PRI_MASK     = 8'hF8,
    parameter logic [7:0] SEC_MASK     = 8'hDE,
    localparam int        NUM_PINS     = 2 * PINS_PER_CTL,
    localparam int        PIN_W        = $clog2(NUM_PINS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                ctl_ready,
    input  logic                      ev_valid,
    input  logic [1:0]                ev_kind,
    input  logic [PIN_W-1:0]          ev_pin,
    input  logic                      slave_raise,
    input  logic                      cfg_wr,
    input  logic                      cfg_sel,
    input  logic [PINS_PER_CTL-1:0]   cfg_wdata,
    output logic [PINS_PER_CTL-1:0]   cfg_rdata,
    output logic [NUM_PINS-1:0]       req_set,
    output logic [NUM_PINS-1:0]       req_clr,
    output logic [NUM_PINS*CNT_W-1:0] pin_count,
    output logic                      uflow_err
);
    import irq_latch_pkg::*;

    ev_kind_e            kind;
    logic                want_up, want_dn, casc_go;
    logic [NUM_PINS-1:0] level_v, uflow_v;

    assign kind    = ev_kind_e'(ev_kind);
    assign want_up = (kind == EV_ASSERT)   || (kind == EV_PULSE);
    assign want_dn = (kind == EV_DEASSERT) || (kind == EV_PULSE);
    assign casc_go = slave_raise && ctl_ready[0];

    trig_mode_regs #(
        .REG_W  (PINS_PER_CTL),
        .MASK_P (PRI_MASK),
        .MASK_S (SEC_MASK)
    ) u_modes (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .sel     (cfg_sel),
        .wr_data (cfg_wdata),
        .rd_data (cfg_rdata),
        .level_o (level_v)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic hit, inc, dec;
        assign hit = ev_valid && (ev_pin == PIN_W'(i)) && ctl_ready[i / PINS_PER_CTL];
        if (i == CASCADE_PIN) begin : g_casc
            assign inc = casc_go || (hit && want_up);
            assign dec = casc_go || (hit && want_dn);
        end else begin : g_plain
            assign inc = hit && want_up;
            assign dec = hit && want_dn;
        end

        pin_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .do_inc  (inc),
            .do_dec  (dec),
            .level   (level_v[i]),
            .cnt_q   (pin_count[i*CNT_W +: CNT_W]),
            .set_q   (req_set[i]),
            .clr_q   (req_clr[i]),
            .uflow_o (uflow_v[i])
        );
    end

    // Latch any counter underflow until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            uflow_err <= 1'b0;
        else if (|uflow_v)
            uflow_err <= 1'b1;
    end

    AST_STICKY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        uflow_err |=> uflow_err); // R10
    AST_NOT_READY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_pin[PIN_W-1] && !ctl_ready[1])
        |=> ($stable(pin_count[NUM_PINS*CNT_W-1 : PINS_PER_CTL*CNT_W])
             && req_set[NUM_PINS-1:PINS_PER_CTL] == '0
             && req_clr[NUM_PINS-1:PINS_PER_CTL] == '0)); // R8
    AST_CASCADE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        casc_go |=> $stable(pin_count[CASCADE_PIN*CNT_W +: CNT_W])); // R9
endmodule

// File: tb/irq_trigger_latch_bench.sv
module irq_trigger_latch_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ctl_ready = 2'b00;
    logic        ev_valid = 1'b0;
    logic [1:0]  ev_kind = 2'b00;
    logic [3:0]  ev_pin = 4'd0;
    logic        slave_raise = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic [15:0] req_set, req_clr;
    logic [63:0] pin_count;
    logic        uflow_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_trigger_latch u_irq_trigger_latch (
        .clk(clk), .rst_n(rst_n), .ctl_ready(ctl_ready),
        .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_pin(ev_pin),
        .slave_raise(slave_raise), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_set(req_set),
        .req_clr(req_clr), .pin_count(pin_count), .uflow_err(uflow_err)
    );

    // kind[41:40] pin[39:36] set[35:20] clr[19:4] count[3:0]
    localparam int NVEC = 16;
    localparam logic [41:0] VEC [NVEC] = '{
        {2'b01, 4'd0,  16'h0001, 16'h0000, 4'd1},  // R2 edge 0->1
        {2'b01, 4'd0,  16'h0000, 16'h0000, 4'd2},  // R2 edge 1->2 silent
        {2'b10, 4'd0,  16'h0000, 16'h0000, 4'd1},  // R1
        {2'b10, 4'd0,  16'h0000, 16'h0000, 4'd0},  // R4 edge no clear
        {2'b01, 4'd3,  16'h0008, 16'h0000, 4'd1},  // R3
        {2'b01, 4'd3,  16'h0008, 16'h0000, 4'd2},  // R3
        {2'b10, 4'd3,  16'h0008, 16'h0000, 4'd1},  // R3
        {2'b10, 4'd3,  16'h0000, 16'h0008, 4'd0},  // R4 level clear
        {2'b11, 4'd5,  16'h0000, 16'h0020, 4'd0},  // R5 level pulse
        {2'b11, 4'd1,  16'h0002, 16'h0000, 4'd0},  // R5 edge pulse
        {2'b01, 4'd9,  16'h0200, 16'h0000, 4'd1},  // R6 secondary level
        {2'b11, 4'd9,  16'h0200, 16'h0000, 4'd1},  // R5 pulse at 1
        {2'b01, 4'd13, 16'h2000, 16'h0000, 4'd1},  // R6 fixed edge
        {2'b10, 4'd13, 16'h0000, 16'h0000, 4'd0},  // R4
        {2'b01, 4'd8,  16'h0100, 16'h0000, 4'd1},  // R6
        {2'b10, 4'd9,  16'h0000, 16'h0200, 4'd0}   // R4
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] k, input logic [3:0] p, input logic casc);
        @(negedge clk);
        ev_valid = (k != 2'b00) || 1'b0; ev_kind = k; ev_pin = p; slave_raise = casc;
        @(posedge clk);
        @(negedge clk);
        ev_valid = 1'b0; ev_kind = 2'b00; slave_raise = 1'b0;
    endtask

    task automatic cfg_write(input logic s, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ev_valid = 1'b0; slave_raise = 1'b0; cfg_wr = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [3:0] cnt_of(input int p);
        return pin_count[p*4 +: 4];
    endfunction

    initial begin
        do_reset();
        // R12: reset state
        check("R12 reset counts", pin_count, 64'h0);
        check("R12 reset set", {48'h0, req_set}, 64'h0);
        check("R12 reset clr", {48'h0, req_clr}, 64'h0);
        check("R12 reset err", {63'h0, uflow_err}, 64'h0);
        cfg_sel = 1'b0; #1;
        check("R7 reset primary mode", {56'h0, cfg_rdata}, 64'h0);

        // R7: masked writes
        cfg_write(1'b0, 8'hFF);
        cfg_write(1'b1, 8'hFF);
        cfg_sel = 1'b0; #1;
        check("R7 primary mask", {56'h0, cfg_rdata}, 64'hF8);
        cfg_sel = 1'b1; #1;
        check("R7 secondary mask", {56'h0, cfg_rdata}, 64'hDE);

        // Table walk with both controllers ready
        ctl_ready = 2'b11;
        for (int v = 0; v < NVEC; v++) begin
            send(VEC[v][41:40], VEC[v][39:36], 1'b0);
            check($sformatf("R1-vector%0d set", v), {48'h0, req_set}, {48'h0, VEC[v][35:20]});
            check($sformatf("R1 vector%0d clr", v), {48'h0, req_clr}, {48'h0, VEC[v][19:4]});
            check($sformatf("R1 vector%0d count", v), {60'h0, cnt_of(int'(VEC[v][39:36]))},
                  {60'h0, VEC[v][3:0]});
        end
        // R12: strobe lasts one cycle
        send(2'b01, 4'd4, 1'b0);
        check("R12 strobe high", {48'h0, req_set}, 64'h0010);
        @(negedge clk);
        check("R12 strobe gone", {48'h0, req_set}, 64'h0);
        // R1: no-op kind
        send(2'b00, 4'd4, 1'b0);
        check("R1 nop count", {60'h0, cnt_of(4)}, 64'd1);

        // R11: saturation on edge pin 0
        for (int n = 0; n < 15; n++) send(2'b01, 4'd0, 1'b0);
        check("R11 count at 15", {60'h0, cnt_of(0)}, 64'd15);
        send(2'b01, 4'd0, 1'b0);
        check("R11 saturated count", {60'h0, cnt_of(0)}, 64'd15);
        check("R11 no set at 15", {48'h0, req_set}, 64'h0);

        // R10: underflow on pin 7
        check("R10 err before", {63'h0, uflow_err}, 64'h0);
        send(2'b10, 4'd7, 1'b0);
        check("R10 count stays 0", {60'h0, cnt_of(7)}, 64'd0);
        check("R10 no clear", {48'h0, req_clr}, 64'h0);
        check("R10 err set", {63'h0, uflow_err}, 64'h1);
        @(negedge clk);
        check("R10 err sticky", {63'h0, uflow_err}, 64'h1);

        // R8: secondary not ready
        do_reset();
        ctl_ready = 2'b01;
        send(2'b01, 4'd10, 1'b0);
        check("R8 ignored count", {60'h0, cnt_of(10)}, 64'd0);
        check("R8 ignored set", {48'h0, req_set}, 64'h0);
        send(2'b01, 4'd4, 1'b0);
        check("R8 primary still active", {60'h0, cnt_of(4)}, 64'd1);
        check("R6 pin 4 set", {48'h0, req_set}, 64'h0010);
        ctl_ready = 2'b10;
        send(2'b01, 4'd4, 1'b0);
        check("R8 primary not ready", {60'h0, cnt_of(4)}, 64'd1);

        // R9: cascade pulse
        ctl_ready = 2'b11;
        send(2'b00, 4'd0, 1'b1);
        check("R9 cascade set", {48'h0, req_set}, 64'h0004);
        check("R9 cascade count", {60'h0, cnt_of(2)}, 64'd0);
        send(2'b01, 4'd2, 1'b1);
        check("R9 cascade overrides event", {60'h0, cnt_of(2)}, 64'd0);
        ctl_ready = 2'b10;
        send(2'b00, 4'd0, 1'b1);
        check("R9 cascade gated", {48'h0, req_set}, 64'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule